// File: doc/BRIEF.md
# Dithered Third-Order Sigma-Delta Modulator

This block turns a stream of oversampled, signed samples into a 5-bit code for a multi-level DAC. An interpolator upstream supplies the samples, one sample for each cycle in which `en_i` is high, at 128 or 256 times the base rate. The block produces one code for each accepted sample. A unit-element selector downstream reads the code when `valid_o` is high.

The loop is a third-order feed-forward design. Three delaying integrators run in cascade on the error between the input and the quantized level. The quantizer input is the input sample plus the three integrator outputs weighted 3, 3 and 1. With these weights, the quantization error reaches the output through exactly (1 - z^-1)^3. A maximal-length 35-bit LFSR adds a small pseudo-random offset at the quantizer input, which breaks up idle tones. The offset is less than half a quantizer step. The quantizer is uniform and mid-rise, and it clips to its 32 codes.

Top module: `sdm3_dither_mod`

## Requirements
- R1: While rst_ni is low, code_o and valid_o are 0, all three integrators are zero and the LFSR holds the value 1.
- R2: valid_o is 1 in the cycle after each clock edge with en_i high, and 0 in the cycle after each clock edge with en_i low.
- R3: Clock edges with en_i low change neither code_o nor the integrator or LFSR state. The next accepted sample therefore yields the same code as it would with no gap.
- R4: For quantizer input v (input LSB units), the code is c = floor(v / 2^19) + 16, clipped to the range 0..31, and the fed-back level is (2c - 31) * 2^18. When c is in 1..30, the level is within 2^18 of v.
- R5: An input at positive full scale gives code 31. An input at negative full scale gives code 0.
- R6: The LFSR is a 35-bit Fibonacci register. Each accepted sample shifts it left by one, and the new bit 0 is bit 34 XOR bit 32. The dither for a sample is (s[7:0] - 128) * 2^9, where s is the LFSR value before the shift.
- R7: The output level y satisfies y = u + (1 - z^-1)^3 q exactly. Here u is the input and q is y minus the undithered quantizer input.
- R8: For a constant input, the sum of (level - input) over any run that starts from reset stays below 2^21 in magnitude.
- R9: No integrator overflows its width while |x_i| stays within 80 % of full scale.
- R10: The LFSR never reaches the all-zero state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| en_i | input | 1 | Sample enable; x_i is accepted on this edge |
| x_i | input | 24 | Signed oversampled input sample |
| code_o | output | 5 | Quantizer code, 0..31 |
| valid_o | output | 1 | High for one cycle after each accepted sample |

## Verification
On every cycle the assertions check the enable-to-valid timing and that code, integrators and LFSR hold while no sample arrives. They also check that the LFSR never becomes zero, that no integrator add overflows, and that the quantization error stays within half a step when the quantizer is not clipping. Only the bench scenarios can show the exact third-order shaping of the quantization error, the dither sequence and the DC accuracy of the output. The bench does this by comparing every code against an error-feedback model that is structured differently from the design, and by summing levels over a long DC run. Full-scale clipping and the effect of gaps between enables on later codes are also shown only by directed scenarios.

// File: rtl/sdm_pkg.sv
package sdm_pkg;
  localparam int unsigned LOOP_ORDER = 3;

  // feed-forward weight of integrator k; 3,3,1 gives NTF (1 - z^-1)^3
  function automatic int ff_gain(input int unsigned k);
    case (k)
      0:       return 3;
      1:       return 3;
      default: return 1;
    endcase
  endfunction
endpackage

// File: rtl/sdm_lfsr.sv
module sdm_lfsr #(
  parameter int unsigned W    = 35,
  parameter int unsigned TAP  = 33,
  parameter logic [W-1:0] SEED = 1
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         en_i,
  output logic [W-1:0] state_o
);
  logic fb;
  assign fb = state_o[W-1] ^ state_o[TAP-1];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   state_o <= SEED;
    else if (en_i) state_o <= {state_o[W-2:0], fb};
  end

  a_r10_lfsr_nonzero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    state_o != '0);
  a_r3_lfsr_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> $stable(state_o));
endmodule

// File: rtl/sdm_integ.sv
module sdm_integ #(
  parameter int unsigned W = 40
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                en_i,
  input  logic signed [W-1:0] d_i,
  output logic signed [W-1:0] acc_o
);
  logic signed [W:0] wide;
  assign wide = (W+1)'(acc_o) + (W+1)'(d_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   acc_o <= '0;
    else if (en_i) acc_o <= wide[W-1:0];
  end

  a_r9_no_overflow: assert property (@(posedge clk_i) disable iff (!rst_ni)
    en_i |-> (wide[W] == wide[W-1]));
  a_r3_integ_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> $stable(acc_o));
endmodule

// File: rtl/sdm_loop_filter.sv
module sdm_loop_filter
  import sdm_pkg::*;
#(
  parameter int unsigned INT_W = 40,
  parameter int unsigned SUM_W = 44
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    en_i,
  input  logic signed [INT_W-1:0] err_i,
  output logic signed [SUM_W-1:0] sum_o
);
  logic signed [INT_W-1:0] din [LOOP_ORDER];
  logic signed [INT_W-1:0] acc [LOOP_ORDER];

  for (genvar k = 0; k < LOOP_ORDER; k++) begin : g_stage
    if (k == 0) begin : g_head
      assign din[k] = err_i;
    end else begin : g_chain
      assign din[k] = acc[k-1];
    end
    sdm_integ #(.W(INT_W)) u_integ (
      .clk_i (clk_i),
      .rst_ni(rst_ni),
      .en_i  (en_i),
      .d_i   (din[k]),
      .acc_o (acc[k])
    );
  end

  always_comb begin
    sum_o = '0;
    for (int k = 0; k < LOOP_ORDER; k++)
      sum_o = sum_o + SUM_W'(acc[k]) * SUM_W'(ff_gain(k));
  end
endmodule

// File: rtl/sdm_quant.sv
module sdm_quant #(
  parameter int unsigned SUM_W   = 44,
  parameter int unsigned CODE_W  = 5,
  parameter int unsigned HALF_SH = 18,
  localparam int unsigned LVL_W  = CODE_W + 2 + HALF_SH
) (
  input  logic signed [SUM_W-1:0] v_i,
  output logic        [CODE_W-1:0] code_o,
  output logic signed [LVL_W-1:0]  level_o
);
  localparam int NLEV = 1 << CODE_W;
  localparam logic signed [SUM_W-1:0] IDX_HI = SUM_W'(NLEV/2 - 1);
  localparam logic signed [SUM_W-1:0] IDX_LO = -SUM_W'(NLEV/2);
  localparam logic signed [SUM_W-1:0] IDX_OF = SUM_W'(NLEV/2);

  logic signed [SUM_W-1:0] idx, idx_off;
  logic signed [CODE_W+1:0] odd;

  always_comb begin
    idx     = v_i >>> (HALF_SH + 1);
    idx_off = idx + IDX_OF;
    if (idx > IDX_HI)      code_o = '1;
    else if (idx < IDX_LO) code_o = '0;
    else                   code_o = idx_off[CODE_W-1:0];
  end

  // odd level 2c+1-NLEV, then scaled by half a step
  assign odd     = $signed({1'b0, code_o, 1'b1}) - $signed((CODE_W+2)'(NLEV));
  assign level_o = LVL_W'(odd) <<< HALF_SH;
endmodule

// File: rtl/sdm3_dither_mod.sv
module sdm3_dither_mod #(
  parameter int unsigned IN_W      = 24,
  parameter int unsigned CODE_W    = 5,
  parameter int unsigned INT_GUARD = 16,
  parameter int unsigned LFSR_W    = 35,
  parameter int unsigned LFSR_TAP  = 33,
  parameter int unsigned DITH_W    = 8,
  parameter int unsigned DITH_SH   = 9
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic                   en_i,
  input  logic signed [IN_W-1:0] x_i,
  output logic [CODE_W-1:0]      code_o,
  output logic                   valid_o
);
  localparam int unsigned INT_W   = IN_W + INT_GUARD;
  localparam int unsigned SUM_W   = INT_W + 4;
  localparam int unsigned HALF_SH = IN_W - 1 - CODE_W;
  localparam int unsigned LVL_W   = CODE_W + 2 + HALF_SH;
  localparam int NLEV = 1 << CODE_W;
  localparam logic signed [SUM_W-1:0] HALF = SUM_W'(1) <<< HALF_SH;

  logic [LFSR_W-1:0]        lfsr;
  logic signed [DITH_W-1:0] dith_c;
  logic signed [SUM_W-1:0]  dith, filt, qin_nd, qin, qerr;
  logic signed [INT_W-1:0]  err;
  logic signed [LVL_W-1:0]  level;
  logic [CODE_W-1:0]        code_d;

  sdm_lfsr #(.W(LFSR_W), .TAP(LFSR_TAP), .SEED(LFSR_W'(1))) u_lfsr (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .en_i   (en_i),
    .state_o(lfsr)
  );

  // offset-binary LSBs to two's complement, centred on zero
  assign dith_c = $signed({~lfsr[DITH_W-1], lfsr[DITH_W-2:0]});
  assign dith   = SUM_W'(dith_c) <<< DITH_SH;

  sdm_loop_filter #(.INT_W(INT_W), .SUM_W(SUM_W)) u_filt (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .en_i  (en_i),
    .err_i (err),
    .sum_o (filt)
  );

  assign qin_nd = SUM_W'(x_i) + filt;
  assign qin    = qin_nd + dith;

  sdm_quant #(.SUM_W(SUM_W), .CODE_W(CODE_W), .HALF_SH(HALF_SH)) u_quant (
    .v_i    (qin),
    .code_o (code_d),
    .level_o(level)
  );

  assign err  = INT_W'(x_i) - INT_W'(level);
  assign qerr = SUM_W'(level) - qin;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      code_o  <= '0;
      valid_o <= 1'b0;
    end else begin
      valid_o <= en_i;
      if (en_i) code_o <= code_d;
    end
  end

  a_r2_valid_after_en: assert property (@(posedge clk_i) disable iff (!rst_ni)
    en_i |=> valid_o);
  a_r2_no_valid_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> !valid_o);
  a_r3_code_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> $stable(code_o));
  a_r4_error_bound: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && code_d != '0 && code_d != CODE_W'(NLEV-1)) |->
      (qerr <= HALF && qerr >= -HALF));
endmodule

// File: tb/sdm3_dither_mod_bench.sv
module sdm3_dither_mod_bench;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic en = 1'b0;
  logic signed [23:0] x = '0;
  logic [4:0] code;
  logic valid;
  int checks = 0;
  int errors = 0;

  longint q1, q2, q3;
  logic [34:0] m_lfsr;

  always #4 clk = ~clk;

  sdm3_dither_mod u_sdm3_dither_mod (
    .clk_i(clk), .rst_ni(rst_n), .en_i(en), .x_i(x),
    .code_o(code), .valid_o(valid)
  );

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic longint lvl_of(input int c);
    return longint'(2*c - 31) * 262144;
  endfunction

  // error-feedback reference: y = u + (1-z^-1)^3 q
  function automatic int ref_step(input longint u);
    longint d, wnd, w, k, y;
    int c;
    d   = (longint'(m_lfsr[7:0]) - 128) * 512;
    wnd = u - 3*q1 + 3*q2 - q3;
    w   = wnd + d;
    k   = w >>> 19;
    c   = (k > 15) ? 31 : (k < -16) ? 0 : int'(k) + 16;
    y   = lvl_of(c);
    q3 = q2; q2 = q1; q1 = y - wnd;
    m_lfsr = {m_lfsr[33:0], m_lfsr[34] ^ m_lfsr[32]};
    return c;
  endfunction

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; en = 1'b0; x = '0;
    @(negedge clk); @(negedge clk);
    rst_n = 1'b1;
    q1 = 0; q2 = 0; q3 = 0; m_lfsr = 35'd1;
  endtask

  // called at a negedge; returns code registered at the following posedge
  task automatic drive(input longint u, output int got);
    x = u[23:0]; en = 1'b1;
    @(negedge clk);
    en = 1'b0;
    got = int'(code);
  endtask

  task automatic run_model(input longint u, input string req, output int got);
    int exp;
    exp = ref_step(u);
    drive(u, got);
    chk(got == exp, req, got, exp);
  endtask

  task automatic t_reset_state();
    @(negedge clk); rst_n = 1'b0;
    @(negedge clk);
    chk(code == 0, "R1 code in reset", code, 0);
    chk(valid == 0, "R1 valid in reset", valid, 0);
    do_reset();
  endtask

  task automatic t_zero_input();
    int got, c0;
    bit moved = 0;
    do_reset();
    for (int i = 0; i < 300; i++) begin
      run_model(0, "R6 R7 zero input", got);
      if (i == 0) c0 = got; else if (got != c0) moved = 1;
    end
    chk(moved, "R6 dithered idle codes vary", moved, 1);
  endtask

  task automatic t_dc();
    int got;
    do_reset();
    for (int i = 0; i < 500; i++) run_model(2516582, "R7 dc +0.3", got);
    do_reset();
    for (int i = 0; i < 500; i++) run_model(-5872025, "R7 dc -0.7", got);
  endtask

  task automatic t_ramp();
    int got;
    longint u = 0, stp = 40000;
    do_reset();
    for (int i = 0; i < 1200; i++) begin
      run_model(u, "R7 R9 triangle", got);
      u += stp;
      if (u > 6600000 || u < -6600000) stp = -stp;
    end
  endtask

  task automatic t_full_scale();
    int got;
    do_reset();
    for (int i = 0; i < 6; i++) begin
      void'(ref_step(8388607));
      drive(8388607, got);
      chk(got == 31, "R5 positive full scale", got, 31);
    end
    do_reset();
    for (int i = 0; i < 6; i++) begin
      void'(ref_step(-8388608));
      drive(-8388608, got);
      chk(got == 0, "R5 negative full scale", got, 0);
    end
  endtask

  task automatic t_gapped();
    int got, held;
    do_reset();
    for (int i = 0; i < 60; i++) begin
      run_model(3000000 - i*90000, "R3 R7 gapped stream", got);
      chk(valid == 1, "R2 valid after enable", valid, 1);
      held = int'(code);
      for (int g = 0; g < (i % 4); g++) begin
        @(negedge clk);
        chk(valid == 0, "R2 no valid when idle", valid, 0);
        chk(int'(code) == held, "R3 code held when idle", code, held);
      end
    end
  endtask

  task automatic t_dc_mean();
    int got;
    longint u = 3355443, sum = 0;
    do_reset();
    for (int i = 0; i < 1024; i++) begin
      drive(u, got);
      sum += lvl_of(got) - u;
    end
    chk(sum < 2097152 && sum > -2097152, "R8 dc mean error", sum, 0);
  endtask

  initial begin
    #1_000_000;
    errors++; checks++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    t_reset_state();
    t_zero_input();
    t_dc();
    t_ramp();
    t_full_scale();
    t_gapped();
    t_dc_mean();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule